// File: doc/BRIEF.md
# Flag-Setting ALU with Arithmetic Shifter

This block is the integer execute stage of a small processor datapath. Each cycle it takes an operation code, two operands and a five-bit shift field, and produces a combinational result. It also holds a four-bit condition register with negative, zero, carry and overflow bits. That register is written on the rising clock edge when the write enable is high. Every operation has its own rule for which condition bits it may touch. The carry-in for add-with-carry and the preserved carry of a do-nothing shift both come from the stored register, so a chain of operations can pass carry from one cycle to the next.

The shifter is arithmetic: it shifts right and fills with the sign. It has two forms. The immediate form reads a five-bit field, and a field of zero means a full-width shift. The register form reads only the low byte of the second operand. In that form a zero amount leaves the operand and the carry as they are, and an amount of the data width or more saturates to sign fill. A third add variant returns the sum without touching any condition bit, so it can compute addresses without disturbing a pending compare. Register file, decode and condition evaluation live outside the block.

Top module: `flag_alu`

## Requirements
- R1: op_sel 0 (add) gives result = opa + opb. When flag_we is high, the next edge loads N = result bit 31, Z = (result == 0), C = carry-out of the add, V = signed overflow. The condition register is packed as flags[3]=N, flags[2]=Z, flags[1]=C, flags[0]=V.
- R2: op_sel 1 (add with carry) gives result = opa + opb + stored C, and updates all four bits as in R1.
- R3: op_sel 2 (AND) gives result = opa & opb, updates N and Z only, and keeps C and V.
- R4: op_sel 3 (immediate arithmetic shift right) shifts opa by shamt_imm. For amounts 1 to 31, C takes opa bit (amount - 1). For shamt_imm = 0 the shift is 32: the result is 32 copies of opa[31] and C = opa[31]. N and Z follow the result and V is kept.
- R5: op_sel 4 (register arithmetic shift right) takes its amount from opb[7:0] only; opb[31:8] has no effect. Amounts 1 to 31 behave as in R4, N and Z follow the result, and V is kept.
- R6: In op_sel 4, an amount byte of 0 gives result = opa and keeps C, with N and Z taken from opa. An amount byte of 32 or more gives 32 copies of opa[31] and C = opa[31].
- R7: op_sel 5 (non-flag add) gives result = opa + opb and leaves all four condition bits unchanged.
- R8: op_sel 6 and 7 are reserved: the result is 0 and the condition bits are unchanged.
- R9: With flag_we low, the condition register holds its value whatever the operation; the result is still produced.
- R10: While rst_n is low the condition register is all zero. Flag updates become visible after the rising edge on which flag_we is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation code (0 add, 1 add with carry, 2 AND, 3 immediate shift, 4 register shift, 5 non-flag add, 6-7 reserved) |
| opa | input | 32 | First operand; value shifted by both shift forms |
| opb | input | 32 | Second operand; low byte is the register shift amount |
| shamt_imm | input | 5 | Immediate shift amount, 0 meaning 32 |
| flag_we | input | 1 | Condition register write enable |
| result | output | 32 | Combinational operation result |
| flags | output | 4 | Condition register {N, Z, C, V} |

## Verification
In a single cycle the block both reads the stored carry and writes a new one. Add with carry uses the old C as carry-in, and a register shift by zero returns the old C as its next value, while the same edge may overwrite that bit. The bench provokes this with back-to-back add-with-carry chains whose carries ripple. It also issues zero-amount register shifts right after carry-setting adds, and alternates enabled and disabled writes. A behavioural model holds its own condition register, predicts the result and the post-edge flags every cycle, and any difference in either is judged a fault.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    ALU_ADD     = 3'd0,
    ALU_ADC     = 3'd1,
    ALU_AND     = 3'd2,
    ALU_ASR_IMM = 3'd3,
    ALU_ASR_REG = 3'd4,
    ALU_ADD_NF  = 3'd5,
    ALU_RSV6    = 3'd6,
    ALU_RSV7    = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  typedef struct packed {
    logic nz;
    logic c;
    logic v;
  } flag_upd_t;

  localparam int unsigned FLAG_W = 4;

endpackage

// File: rtl/fa_adder.sv
module fa_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int unsigned EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  end

  assign sum_o  = wide_sum[WIDTH-1:0];
  assign cout_o = wide_sum[EXT_W-1];
  // signed overflow: like-signed operands giving an opposite-signed sum
  assign ovf_o  = (a_i[WIDTH-1] == b_i[WIDTH-1]) &&
                  (wide_sum[WIDTH-1] != a_i[WIDTH-1]);

endmodule

// File: rtl/fa_asr.sv
module fa_asr #(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned AMT_W     = $clog2(WIDTH),
  parameter int unsigned REG_AMT_W = 8
) (
  input  logic [WIDTH-1:0]     src_i,
  input  logic [AMT_W-1:0]     imm_amt_i,
  input  logic [REG_AMT_W-1:0] reg_amt_i,
  input  logic                 use_reg_i,
  output logic [WIDTH-1:0]     res_o,
  output logic                 c_o,
  output logic                 c_keep_o
);

  localparam logic [REG_AMT_W-1:0] SAT_AMT = REG_AMT_W'(WIDTH);

  logic             sign;
  logic             full;
  logic             hold;
  logic [AMT_W-1:0] amt;
  logic [AMT_W-1:0] amt_m1;
  logic             tap;
  logic [WIDTH-1:0] stage [AMT_W+1];

  assign sign = src_i[WIDTH-1];

  // amount decode: zero and saturating encodings
  always_comb begin
    hold = 1'b0;
    full = 1'b0;
    amt  = imm_amt_i;
    if (use_reg_i) begin
      amt = reg_amt_i[AMT_W-1:0];
      if (reg_amt_i == '0) begin
        hold = 1'b1;
      end else if (reg_amt_i >= SAT_AMT) begin
        full = 1'b1;
      end
    end else if (imm_amt_i == '0) begin
      full = 1'b1;
    end
  end

  // logarithmic shifter, one stage per amount bit
  assign stage[0] = src_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    assign stage[k+1] = amt[k] ? {{SH{sign}}, stage[k][WIDTH-1:SH]} : stage[k];
  end

  // last bit shifted out
  assign amt_m1 = amt - AMT_W'(1);
  assign tap    = src_i[amt_m1];

  assign res_o    = full ? {WIDTH{sign}} : stage[AMT_W];
  assign c_o      = full ? sign : tap;
  assign c_keep_o = hold;

endmodule

// File: rtl/fa_flag_reg.sv
module fa_flag_reg
  import flag_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  flag_upd_t  upd_i,
  input  alu_flags_t cand_i,
  output alu_flags_t q_o
);

  alu_flags_t q;
  alu_flags_t d;

  always_comb begin
    d = q;
    if (we_i) begin
      if (upd_i.nz) begin
        d.n = cand_i.n;
        d.z = cand_i.z;
      end
      if (upd_i.c) begin
        d.c = cand_i.c;
      end
      if (upd_i.v) begin
        d.v = cand_i.v;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end

  assign q_o = q;

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned REG_AMT_W = 8,
  parameter int unsigned AMT_W     = $clog2(WIDTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           op_sel,
  input  logic [WIDTH-1:0]     opa,
  input  logic [WIDTH-1:0]     opb,
  input  logic [AMT_W-1:0]     shamt_imm,
  input  logic                 flag_we,
  output logic [WIDTH-1:0]     result,
  output logic [FLAG_W-1:0]    flags
);

  alu_op_e    op;
  alu_flags_t flags_q;
  alu_flags_t cand;
  flag_upd_t  upd;

  logic [WIDTH-1:0] sum;
  logic             add_cout;
  logic             add_ovf;
  logic             add_cin;
  logic [WIDTH-1:0] sh_res;
  logic             sh_c;
  logic             sh_keep;
  logic             sh_reg;
  logic [WIDTH-1:0] res_mux;

  assign op      = alu_op_e'(op_sel);
  assign add_cin = (op == ALU_ADC) ? flags_q.c : 1'b0;
  assign sh_reg  = (op == ALU_ASR_REG);

  fa_adder #(
    .WIDTH (WIDTH)
  ) i_adder (
    .a_i    (opa),
    .b_i    (opb),
    .cin_i  (add_cin),
    .sum_o  (sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  fa_asr #(
    .WIDTH     (WIDTH),
    .AMT_W     (AMT_W),
    .REG_AMT_W (REG_AMT_W)
  ) i_asr (
    .src_i     (opa),
    .imm_amt_i (shamt_imm),
    .reg_amt_i (opb[REG_AMT_W-1:0]),
    .use_reg_i (sh_reg),
    .res_o     (sh_res),
    .c_o       (sh_c),
    .c_keep_o  (sh_keep)
  );

  // result select and per-operation flag update mask
  always_comb begin
    res_mux = '0;
    upd     = '0;
    cand.c  = add_cout;
    cand.v  = add_ovf;
    unique case (op)
      ALU_ADD, ALU_ADC: begin
        res_mux = sum;
        upd     = '{nz: 1'b1, c: 1'b1, v: 1'b1};
      end
      ALU_AND: begin
        res_mux = opa & opb;
        upd.nz  = 1'b1;
      end
      ALU_ASR_IMM, ALU_ASR_REG: begin
        res_mux = sh_res;
        cand.c  = sh_c;
        upd.nz  = 1'b1;
        upd.c   = !sh_keep;
      end
      ALU_ADD_NF: begin
        res_mux = sum;
      end
      default: begin
        res_mux = '0;
      end
    endcase
    cand.n = res_mux[WIDTH-1];
    cand.z = (res_mux == '0);
  end

  fa_flag_reg i_flag_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (flag_we),
    .upd_i  (upd),
    .cand_i (cand),
    .q_o    (flags_q)
  );

  assign result = res_mux;
  assign flags  = flags_q;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned REG_AMT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             flag_we,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       flags
);

  // R10
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> flags == 4'b0000);

  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));

  // R3
  and_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel == 3'd2) |=> flags[1:0] == $past(flags[1:0]));

  // R4
  shift_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op_sel == 3'd3 || op_sel == 3'd4)) |=> flags[0] == $past(flags[0]));

  // R6
  zero_shift_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd4 && opb[REG_AMT_W-1:0] == '0) |-> result == opa);

  // R6
  zero_shift_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel == 3'd4 && opb[REG_AMT_W-1:0] == '0) |=> flags[1] == $past(flags[1]));

  // R7
  nf_add_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd5) |=> $stable(flags));

  // R8
  rsv_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel[2:1] == 2'b11) |-> result == '0);

  // R8
  rsv_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel[2:1] == 2'b11) |=> $stable(flags));

  // R1
  zero_flag_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel <= 3'd4) |=> flags[2] == ($past(result) == '0));

  // R1
  neg_flag_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel <= 3'd4) |=> flags[3] == $past(result[WIDTH-1]));

endmodule

bind flag_alu flag_alu_chk #(
  .WIDTH     (WIDTH),
  .REG_AMT_W (REG_AMT_W)
) i_flag_alu_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_sel  (op_sel),
  .opa     (opa),
  .opb     (opb),
  .flag_we (flag_we),
  .result  (result),
  .flags   (flags)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op_sel;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [4:0]  shamt_imm;
  logic        flag_we;
  logic [31:0] result;
  logic [3:0]  flags;

  int checks;
  int fails;
  logic [3:0] mflags;

  flag_alu i_flag_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .opa       (opa),
    .opb       (opb),
    .shamt_imm (shamt_imm),
    .flag_we   (flag_we),
    .result    (result),
    .flags     (flags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference: one operation, current flags in, result and next flags out
  function automatic void model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic [4:0] imm, input logic [3:0] fin,
                                output logic [31:0] r, output logic [3:0] fo);
    logic [63:0] s;
    logic [31:0] t;
    logic        c;
    int          n;
    fo = fin;
    r  = '0;
    n  = 0;
    case (op)
      3'd0, 3'd1, 3'd5: begin
        s = {32'd0, a} + {32'd0, b} + ((op == 3'd1) ? 64'(fin[1]) : 64'd0);
        r = s[31:0];
        if (op != 3'd5)
          fo = {r[31], (r == 0), s[32], (a[31] == b[31]) && (r[31] != a[31])};
      end
      3'd2: begin
        r = a & b;
        fo[3] = r[31];
        fo[2] = (r == 0);
      end
      3'd3, 3'd4: begin
        if (op == 3'd3) n = (imm == 0) ? 32 : int'(imm);
        else            n = (b[7:0] > 32) ? 32 : int'(b[7:0]);
        t = a;
        c = fin[1];
        for (int i = 0; i < n; i++) begin
          c = t[0];
          t = {t[31], t[31:1]};
        end
        r = t;
        fo[3] = r[31];
        fo[2] = (r == 0);
        fo[1] = c;
      end
      default: r = '0;
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] op, input logic [31:0] b);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return ((b[7:0] == 0) || (b[7:0] >= 32)) ? "R6" : "R5";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] imm, input logic we);
    logic [31:0] er;
    logic [3:0]  ef;
    op_sel = op; opa = a; opb = b; shamt_imm = imm; flag_we = we;
    #2;
    model(op, a, b, imm, mflags, er, ef);
    check(op_tag(op, b), "result", result, er);
    @(posedge clk);
    #2;
    if (we) mflags = ef;
    check(we ? op_tag(op, b) : "R9", "flags", {28'd0, flags}, {28'd0, mflags});
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; mflags = 4'b0000;
    rst_n = 1'b0; op_sel = 3'd0; opa = '0; opb = '0; shamt_imm = '0; flag_we = 1'b0;
    @(posedge clk); #2;
    // R10: reset state
    check("R10", "flags in reset", {28'd0, flags}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "flags after release", {28'd0, flags}, 32'd0);

    // R1: add corner cases
    run_op(3'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, 1'b1);
    run_op(3'd0, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b1);
    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, 1'b1);
    // R2: carry chain, stored C read and rewritten on the same edge
    run_op(3'd1, 32'hFFFF_FFFF, 32'h0, 5'd0, 1'b1);
    run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b1);
    run_op(3'd1, 32'h0, 32'h0, 5'd0, 1'b1);
    // R3: AND after setting C and V
    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, 1'b1);
    run_op(3'd2, 32'hF0F0_0000, 32'h0F0F_0000, 5'd0, 1'b1);
    run_op(3'd2, 32'h8000_00FF, 32'hFFFF_0001, 5'd0, 1'b1);
    // R4: immediate shift, zero encodes 32
    run_op(3'd3, 32'h8000_0001, 32'h0, 5'd0, 1'b1);
    run_op(3'd3, 32'h4000_0000, 32'h0, 5'd0, 1'b1);
    run_op(3'd3, 32'h0000_0003, 32'h0, 5'd1, 1'b1);
    run_op(3'd3, 32'hC000_0000, 32'h0, 5'd31, 1'b1);
    // R5: register shift uses only the low byte
    run_op(3'd4, 32'h8765_4321, 32'hFFFF_FF04, 5'd0, 1'b1);
    run_op(3'd4, 32'h0000_0100, 32'h1234_5609, 5'd0, 1'b1);
    // R6: zero amount after a carry-setting add, then saturating amounts
    run_op(3'd0, 32'hFFFF_FFFF, 32'h2, 5'd0, 1'b1);
    run_op(3'd4, 32'h0000_0000, 32'hABCD_EF00, 5'd0, 1'b1);
    run_op(3'd4, 32'h8000_0000, 32'h0000_0020, 5'd0, 1'b1);
    run_op(3'd4, 32'h7FFF_FFFF, 32'h0000_00FF, 5'd0, 1'b1);
    run_op(3'd4, 32'h7FFF_FFFF, 32'h0000_0021, 5'd0, 1'b1);
    // R7: non-flag add
    run_op(3'd5, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b1);
    // R8: reserved codes
    run_op(3'd6, 32'h1234_5678, 32'h1, 5'd0, 1'b1);
    run_op(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 1'b1);
    // R9: write enable low
    run_op(3'd0, 32'h0, 32'h0, 5'd0, 1'b0);
    run_op(3'd3, 32'h8000_0000, 32'h0, 5'd0, 1'b0);

    // mixed stream
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 5 == 0) rb[7:0] = 8'($urandom_range(0, 40));
      if (i % 7 == 0) ra = 32'hFFFF_FFFF;
      run_op(3'($urandom_range(0, 7)), ra, rb, 5'($urandom), ($urandom_range(0, 3) != 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule